// File: doc/BRIEF.md
# Programmable Tick Interrupt Timer

This block produces a periodic interrupt from a slow reference. The reference arrives as a one-cycle strobe, `refPulse`, at 32768 Hz in the system clock domain. A free-running divider turns it into a tick clock of 32768 / 2^N Hz, where N comes from a 4-bit field of the control register. A down-counter loads a programmed period and steps once per tick-clock pulse. When it expires it sets a sticky status bit, raises a level interrupt and reloads itself.

Software reaches four word registers through a simple write strobe and a combinational read port. The address decoding is as follows:
- address 0 holds the control word;
- address 1 holds the period;
- address 2 returns the live count and cannot be written;
- address 3 holds the status bit, which is cleared by writing 1 to it.

The counter runs only while both the master enable and the tick enable are set. It is armed only by a rising edge of the tick enable.

Top module: `rtc_tick_timer`

## Requirements
- R1: The divider is a 15-bit count of `refPulse` strobes that runs from reset. A tick-clock pulse occurs on a cycle with `refPulse` high in which the low N bits of that count, taken before it increments, are all ones. N = 0 therefore gives a pulse on every strobe.
- R2: Control register bit layout: bit 0 is the master enable, bits [7:4] are the divider select N, and bit 8 is the tick enable. Only these bits are stored, and all other bits read as 0. A control write applies its N to the divider only when its bit 0 is 1.
- R3: The counter loads the period and starts running only on a control write that has bit 0 = 1 and bit 8 = 1 while the stored bit 8 is 0, and only if the period register is nonzero.
- R4: A control write that clears the master enable, while it is set, stops the counter. A control write that keeps the master enable and clears a set tick enable also stops the counter. A stopped counter holds its value.
- R5: A write to address 1 is accepted only when the data is greater than 2. Otherwise the old period is kept.
- R6: On each tick-clock pulse while running, the counter decrements. If the counter is 1 at that pulse, it instead reloads the period and sets status bit 0. The counter keeps running after an expiry.
- R7: `tickIrq` equals status bit 0. Writing 1 to bit 0 of address 3 clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R8: Reading address 2 returns the live counter value.
- R9: After reset, all registers read 0, the counter is stopped and `tickIrq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refPulse | input | 1 | One-cycle strobe at the 32768 Hz reference rate |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| tickIrq | output | 1 | Level tick interrupt |

## Verification
The stimulus covers several cases:
- An arm attempt with a zero period, which must leave the counter idle.
- A run at N = 0 with a period of 5, where every strobe steps the counter.
- A change of N to 2 and then to 3 while running, which separates a correct divider from one that ignores the select or counts system clocks.
- A period change in mid-run, which must take effect only at the next reload.
- A master disable followed by a re-enable with the tick bit still stored, which must not restart the counter and so tells an edge-armed start from a level-armed one.
- A write-0 followed by a write-1 to the status register, which separates the write-1-to-clear rule from a plain overwrite.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_COUNT  = 2'd2;
  localparam logic [1:0] ADDR_STAT   = 2'd3;

  localparam int CTRL_W      = 9;
  localparam int BIT_MASTER  = 0;
  localparam int BIT_TICKEN  = 8;
  localparam int SEL_LSB     = 4;

  typedef struct packed {
    logic load;
    logic step;
  } dpCmd_t;
endpackage

// File: rtl/rtc_tick_ctrl.sv
module rtc_tick_ctrl
  import rtc_tick_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refPulse,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [31:0]      wrData,
  input  logic             atLast,
  output dpCmd_t           dpCmd,
  output logic [CNT_W-1:0] periodReg,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic             statusBit,
  output logic             running,
  output logic             expire
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMask;
  logic [SEL_W-1:0] effSel;
  logic             tickPulse;
  logic             ctrlWr, startReq, stopReq;
  logic             newMaster, newTick, oldMaster, oldTick;

  assign divMask   = ~({DIV_W{1'b1}} << effSel);
  assign tickPulse = refPulse && ((divCnt & divMask) == divMask);

  assign ctrlWr    = wrEn && (addr == ADDR_CTRL);
  assign newMaster = wrData[BIT_MASTER];
  assign newTick   = wrData[BIT_TICKEN];
  assign oldMaster = ctrlReg[BIT_MASTER];
  assign oldTick   = ctrlReg[BIT_TICKEN];

  always_comb begin
    startReq = ctrlWr && newMaster && newTick && !oldTick && (periodReg != '0);
    stopReq  = ctrlWr && ((!newMaster && oldMaster) ||
                          (newMaster && !newTick && oldTick));
    dpCmd.load = startReq;
    dpCmd.step = running && tickPulse && !startReq && !stopReq;
    expire     = dpCmd.step && atLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      effSel    <= '0;
      ctrlReg   <= '0;
      periodReg <= '0;
      statusBit <= 1'b0;
      running   <= 1'b0;
    end else begin
      if (refPulse) divCnt <= divCnt + 1'b1;
      if (ctrlWr) begin
        ctrlReg <= '0;
        ctrlReg[BIT_MASTER] <= newMaster;
        ctrlReg[BIT_TICKEN] <= newTick;
        ctrlReg[SEL_LSB +: SEL_W] <= wrData[SEL_LSB +: SEL_W];
        if (newMaster) effSel <= wrData[SEL_LSB +: SEL_W];
      end
      if (wrEn && addr == ADDR_PERIOD && wrData > 32'd2)
        periodReg <= wrData[CNT_W-1:0];
      if (startReq)     running <= 1'b1;
      else if (stopReq) running <= 1'b0;
      if (expire)
        statusBit <= 1'b1;
      else if (wrEn && addr == ADDR_STAT && wrData[0])
        statusBit <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_tick_datapath.sv
module rtc_tick_datapath
  import rtc_tick_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           dpCmd,
  input  logic [CNT_W-1:0] periodReg,
  output logic [CNT_W-1:0] count,
  output logic             atLast
);
  assign atLast = (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)
      count <= '0;
    else if (dpCmd.load)
      count <= periodReg;
    else if (dpCmd.step)
      count <= atLast ? periodReg : count - 1'b1;
  end
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
  import rtc_tick_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SEL_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refPulse,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        tickIrq
);
  dpCmd_t            dpCmd;
  logic [CNT_W-1:0]  periodReg;
  logic [CNT_W-1:0]  count;
  logic [CTRL_W-1:0] ctrlReg;
  logic              statusBit, running, expire, atLast;

  rtc_tick_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .atLast(atLast), .dpCmd(dpCmd), .periodReg(periodReg),
    .ctrlReg(ctrlReg), .statusBit(statusBit), .running(running), .expire(expire)
  );

  rtc_tick_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .dpCmd(dpCmd), .periodReg(periodReg),
    .count(count), .atLast(atLast)
  );

  always_comb begin
    case (addr)
      ADDR_CTRL:   rdData = 32'(ctrlReg);
      ADDR_PERIOD: rdData = 32'(periodReg);
      ADDR_COUNT:  rdData = 32'(count);
      default:     rdData = {31'd0, statusBit};
    endcase
  end

  assign tickIrq = statusBit;
endmodule

// File: rtl/rtc_tick_checker.sv
module rtc_tick_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       addr,
  input logic [31:0]      wrData,
  input logic             tickIrq,
  input logic             running,
  input logic             load,
  input logic             expire,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] periodReg
);
  assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rstN)
    load |=> count == $past(periodReg));

  assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !load) |=> $stable(count));

  assert_reject_small_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd1 && wrData <= 32'd2) |=> $stable(periodReg));

  assert_live_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    running |-> count != '0);

  assert_irq_from_expiry_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tickIrq) |-> $past(expire));

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd3 && wrData[0] && !expire) |=> !tickIrq);
endmodule

bind rtc_tick_timer rtc_tick_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .tickIrq(tickIrq), .running(running), .load(dpCmd.load), .expire(expire),
  .count(count), .periodReg(periodReg)
);

// File: tb/sim_rtc_tick_timer.sv
module sim_rtc_tick_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refPulse = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        tickIrq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state
  longint mCtrl, mPeriod, mCount, mPre, mSel;
  bit     mStat, mRun;

  rtc_tick_timer u0 (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tickIrq(tickIrq)
  );

  always #5 clk = ~clk;

  // reference strobe: one cycle in three
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #2;
      refPulse = (k % 3 == 0);
      k++;
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mPeriod = 0; mCount = 0; mPre = 0; mSel = 0;
      mStat = 0; mRun = 0;
    end else begin
      longint msk;
      bit tk, st, sp, stp, ex, cw;
      msk = (longint'(1) << mSel) - 1;
      tk  = refPulse && ((mPre & msk) == msk);
      if (refPulse) mPre = (mPre + 1) % 32768;
      cw = wrEn && addr == 2'd0;
      st = cw && wrData[0] && wrData[8] && !mCtrl[8] && mPeriod != 0;
      sp = cw && ((!wrData[0] && mCtrl[0]) || (wrData[0] && !wrData[8] && mCtrl[8]));
      stp = mRun && tk && !st && !sp;
      ex  = stp && mCount == 1;
      if (st) mCount = mPeriod;
      else if (stp) mCount = ex ? mPeriod : mCount - 1;
      if (wrEn && addr == 2'd1 && wrData > 2) mPeriod = wrData;
      if (cw) begin
        mCtrl = wrData & 32'h1F1;
        if (wrData[0]) mSel = (wrData >> 4) & 15;
      end
      if (st) mRun = 1; else if (sp) mRun = 0;
      if (ex) mStat = 1;
      else if (wrEn && addr == 2'd3 && wrData[0]) mStat = 0;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R7 irq", longint'(tickIrq), longint'(mStat));
      case (addr)
        2'd0: check("R2 ctrl read", longint'(rdData), mCtrl);
        2'd1: check("R5 period read", longint'(rdData), mPeriod);
        2'd2: check("R8 R6 count read", longint'(rdData), mCount);
        default: check("R7 status read", longint'(rdData), longint'(mStat));
      endcase
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #2;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #2;
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic watch(logic [1:0] a, int n);
    @(posedge clk); #2;
    addr = a;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R9: reset state on every register
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      check("R9 reset read", longint'(rdData), 0);
    end
    check("R9 reset irq", longint'(tickIrq), 0);
    // R3: arming with a zero period does nothing
    wr(2'd0, 32'h101);
    watch(2'd2, 20);
    @(negedge clk); check("R3 zero period no start", longint'(rdData), 0);
    wr(2'd0, 32'h001);
    // R5: small values rejected
    wr(2'd1, 32'd2);
    @(negedge clk); addr = 2'd1; #1;
    check("R5 reject 2", longint'(rdData), 0);
    wr(2'd1, 32'd5);
    wr(2'd1, 32'd1);
    @(negedge clk); addr = 2'd1; #1;
    check("R5 keep 5", longint'(rdData), 5);
    // R3 R6 R1: start at N=0
    wr(2'd0, 32'h101);
    watch(2'd2, 60);
    @(negedge clk); check("R6 irq after expiry", longint'(tickIrq), 1);
    // R7: write 0 ignored, write 1 clears
    wr(2'd3, 32'h0);
    watch(2'd3, 2);
    wr(2'd3, 32'h1);
    watch(2'd2, 4);
    // R1 R2: change divider while running, no restart
    wr(2'd0, 32'h121);
    watch(2'd2, 150);
    wr(2'd1, 32'd7);
    watch(2'd2, 200);
    // R4: clear tick enable stops, count held
    wr(2'd0, 32'h021);
    watch(2'd2, 60);
    wr(2'd3, 32'h1);
    // restart, then clear master
    wr(2'd0, 32'h131);
    watch(2'd2, 100);
    wr(2'd0, 32'h130);
    watch(2'd2, 50);
    // R3: master back on with tick still stored: no restart
    wr(2'd0, 32'h101);
    watch(2'd2, 50);
    wr(2'd0, 32'h001);
    wr(2'd0, 32'h101);
    watch(2'd0, 5);
    watch(2'd2, 120);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule